// File: doc/BRIEF.md
# Clock Frequency Monitor With Loss Detection

This block measures a monitored clock against a reference clock. Each rising edge of the monitored clock flips a toggle flop in the monitored domain. The toggle crosses into the reference domain through a two-flop synchronizer, and a change of the synchronized value becomes a one-cycle edge pulse. A window meter counts these pulses over a programmable number of reference cycles. When the window ends, it compares the count with a low and a high threshold.

A separate gap detector counts the reference cycles that pass without an edge pulse. It trips when the monitored clock runs slower than a quarter of the reference or stops altogether. A sudden stop therefore raises a fault even though no window has ended. Every fault sets a sticky status bit, and software clears a status bit by writing one to it.

A three-state controller sequences the block. CM_OFF is the disabled state. Raising the enable moves it from CM_OFF to CM_SETTLE. CM_SETTLE lasts SETTLE_CYC reference cycles, lets the synchronizer flush and discards any start-up indication, and then moves to CM_RUN. CM_RUN measures continuously. Dropping the enable returns the controller from CM_SETTLE or CM_RUN to CM_OFF.

Top module: `clkmon_top`

## Requirements
- R1: While reset is asserted and after it is released with the enable low, the status is 0x00 and all three fault outputs are 0.
- R2: Whenever the enable is low, the status and all fault outputs are 0 from the next reference edge onward.
- R3: In CM_RUN, edges are counted over windows of win_len reference cycles. At the end of a window whose count is below thr_lo, fault_low goes high, and it holds that level until the next window ends.
- R4: At the end of a window whose count is above thr_hi, fault_high goes high. A count equal to either threshold raises neither fault.
- R5: When LOSS_LIMIT (4) consecutive reference cycles pass in CM_RUN with no edge pulse, fault_loss goes high and status bit 3 is set. A monitored clock at exactly a quarter of the reference never trips. A clock at one fifth of the reference does trip.
- R6: A monitored clock that stops completely raises fault_loss and, given thr_lo of at least 1, also fault_low.
- R7: Status bits are sticky. Bit 0 records a low fault, bit 1 a high fault and bit 3 a loss. Bit 2 and bits 7:4 always read 0.
- R8: A clear write (clr_we high) clears exactly the status bits set in clr_mask. If a fault sets a bit in the same cycle as a clear write, the set wins.
- R9: On entry to CM_SETTLE the status is cleared and the gap detector is held idle, so no loss is reported for the first cycles after the enable rises.
- R10: The controller goes from CM_OFF to CM_SETTLE on enable, from CM_SETTLE to CM_RUN after SETTLE_CYC cycles, and from any state to CM_OFF when the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all logic except the toggle flop runs on it |
| ref_rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Clock under observation |
| mon_enable | input | 1 | Enables the monitor |
| win_len | input | WIN_W | Window length in reference cycles |
| thr_lo | input | CNT_W | Low threshold on the window edge count |
| thr_hi | input | CNT_W | High threshold on the window edge count |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 8 | Status bits to clear (write one to clear) |
| status | output | 8 | Sticky status: bit 0 low, bit 1 high, bit 3 loss |
| fault_low | output | 1 | Last window count was below thr_lo |
| fault_high | output | 1 | Last window count was above thr_hi |
| fault_loss | output | 1 | Monitored clock is slower than a quarter of the reference or stopped |

## Verification
The checks assume that the monitored clock runs below half the reference frequency, so that no toggle is lost in the synchronizer. They also assume that thr_lo does not exceed thr_hi and that thresholds change only while the block is disabled. The stimulus keeps within these limits. It uses a 10 ns reference and monitored half-periods that are multiples of 5 ns, started 3 ns off the reference grid, so monitored edges never coincide with reference edges. Configuration changes are made only while the enable is low.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        CM_OFF    = 2'd0,
        CM_SETTLE = 2'd1,
        CM_RUN    = 2'd2
    } cm_state_e;

    localparam int STAT_W   = 8;
    localparam int BIT_LOW  = 0;
    localparam int BIT_HIGH = 1;
    localparam int BIT_LOSS = 3;

    localparam logic [STAT_W-1:0] STAT_VALID =
        STAT_W'((1 << BIT_LOW) | (1 << BIT_HIGH) | (1 << BIT_LOSS));

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic mon_clk,
    output logic edge_pulse
);

    logic                   tog_q;
    logic [SYNC_STAGES:0]   shift_q;

    // one flip per monitored rising edge
    always_ff @(posedge mon_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= ~tog_q;
        end
    end

    // synchronizer stages plus one history stage
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SYNC_STAGES-1:0], tog_q};
        end
    end

    assign edge_pulse = shift_q[SYNC_STAGES] ^ shift_q[SYNC_STAGES-1];

endmodule

// File: rtl/clkmon_loss_det.sv
module clkmon_loss_det #(
    parameter int LOSS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic edge_pulse,
    output logic lost
);

    localparam int GAP_W = $clog2(LOSS_LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(LOSS_LIMIT);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!run || edge_pulse) begin
            gap_q <= '0;
        end else if (gap_q < GAP_LIM) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assign lost = run && (gap_q >= GAP_LIM);

endmodule

// File: rtl/clkmon_win_meter.sv
module clkmon_win_meter #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             edge_pulse,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] thr_hi,
    output logic             done_q,
    output logic             low_q,
    output logic             high_q
);

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             last;

    assign last    = ({1'b0, win_q} + (WIN_W+1)'(1)) >= {1'b0, win_len};
    assign cnt_inc = (edge_pulse && (cnt_q != {CNT_W{1'b1}})) ? cnt_q + CNT_W'(1) : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            low_q  <= 1'b0;
            high_q <= 1'b0;
        end else if (!run) begin
            win_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            low_q  <= 1'b0;
            high_q <= 1'b0;
        end else begin
            done_q <= last;
            if (last) begin
                win_q  <= '0;
                cnt_q  <= '0;
                low_q  <= cnt_inc < thr_lo;
                high_q <= cnt_inc > thr_hi;
            end else begin
                win_q  <= win_q + WIN_W'(1);
                cnt_q  <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
    import clkmon_pkg::*;
#(
    parameter int WIN_W       = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIMIT  = 4,
    parameter int SETTLE_CYC  = SYNC_STAGES + 2
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              mon_clk,
    input  logic              mon_enable,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [CNT_W-1:0]  thr_lo,
    input  logic [CNT_W-1:0]  thr_hi,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status,
    output logic              fault_low,
    output logic              fault_high,
    output logic              fault_loss
);

    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    cm_state_e         st_q, st_d;
    logic [SET_W-1:0]  settle_q;
    logic [STAT_W-1:0] status_q, status_nxt;
    logic              fault_loss_q;
    logic              run;
    logic              edge_pulse;
    logic              loss_now;
    logic              win_done, win_low, win_high;

    assign run = mon_enable && (st_q == CM_RUN);

    clkmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .mon_clk   (mon_clk),
        .edge_pulse(edge_pulse)
    );

    clkmon_loss_det #(.LOSS_LIMIT(LOSS_LIMIT)) u_loss (
        .clk       (ref_clk),
        .rst_n     (ref_rst_n),
        .run       (run),
        .edge_pulse(edge_pulse),
        .lost      (loss_now)
    );

    clkmon_win_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_meter (
        .clk       (ref_clk),
        .rst_n     (ref_rst_n),
        .run       (run),
        .edge_pulse(edge_pulse),
        .win_len   (win_len),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .done_q    (win_done),
        .low_q     (win_low),
        .high_q    (win_high)
    );

    // state register
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            st_q <= CM_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CM_OFF: begin
                if (mon_enable) st_d = CM_SETTLE;
            end
            CM_SETTLE: begin
                if (!mon_enable)              st_d = CM_OFF;
                else if (settle_q == SET_LAST) st_d = CM_RUN;
            end
            CM_RUN: begin
                if (!mon_enable) st_d = CM_OFF;
            end
            default: st_d = CM_OFF;
        endcase
    end

    // next status: clear first, then sets so that a set wins
    always_comb begin
        status_nxt = status_q;
        if (clr_we) status_nxt = status_nxt & ~clr_mask;
        if (win_done && win_low)  status_nxt[BIT_LOW]  = 1'b1;
        if (win_done && win_high) status_nxt[BIT_HIGH] = 1'b1;
        if (loss_now)             status_nxt[BIT_LOSS] = 1'b1;
        status_nxt = status_nxt & STAT_VALID;
    end

    // outputs
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            settle_q     <= '0;
            status_q     <= '0;
            fault_loss_q <= 1'b0;
        end else begin
            settle_q     <= (st_q == CM_SETTLE) ? settle_q + SET_W'(1) : '0;
            fault_loss_q <= mon_enable && loss_now;
            if (!mon_enable || st_q == CM_SETTLE) begin
                status_q <= '0;
            end else begin
                status_q <= status_nxt;
            end
        end
    end

    assign status     = status_q;
    assign fault_low  = win_low;
    assign fault_high = win_high;
    assign fault_loss = fault_loss_q;

endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker
    import clkmon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mon_enable,
    input logic              clr_we,
    input logic [STAT_W-1:0] clr_mask,
    input logic [STAT_W-1:0] status,
    input logic              fault_low,
    input logic              fault_high,
    input logic              fault_loss,
    input cm_state_e         st
);

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_enable |=> (status == '0 && !fault_low && !fault_high && !fault_loss));

    // R7
    sticky_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_LOW] && mon_enable && st == CM_RUN && !(clr_we && clr_mask[BIT_LOW]))
        |=> status[BIT_LOW]);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~STAT_VALID) == '0);

    // R5
    loss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_loss |-> status[BIT_LOSS]);

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_enable) |=> (status == '0 && !fault_loss));

    // R10
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CM_OFF) |=> (st != CM_RUN));

endmodule

bind clkmon_top clkmon_checker u_chk (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .mon_enable(mon_enable),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .status    (status),
    .fault_low (fault_low),
    .fault_high(fault_high),
    .fault_loss(fault_loss),
    .st        (st_q)
);

// File: tb/clkmon_top_test.sv
module clkmon_top_test;

    localparam int PERIOD = 10;
    localparam int NV     = 9;

    // window, monitored half period (0 = stopped), lo, hi, status, f_low, f_high, f_loss (2 = skip)
    localparam int V_WIN  [NV] = '{40, 40, 40, 40, 40, 40, 40, 20, 40};
    localparam int V_HALF [NV] = '{10, 10, 10, 10, 15, 20, 25, 10,  0};
    localparam int V_LO   [NV] = '{10, 25,  5, 20, 10,  8,  4, 11,  1};
    localparam int V_HI   [NV] = '{30, 40, 15, 20, 16, 12, 12, 30, 50};
    localparam int V_ST   [NV] = '{ 0,  1,  2,  0,  0,  0,  8,  1,  9};
    localparam int V_FL   [NV] = '{ 0,  1,  0,  0,  0,  0,  0,  1,  1};
    localparam int V_FH   [NV] = '{ 0,  0,  1,  0,  0,  0,  0,  0,  0};
    localparam int V_FX   [NV] = '{ 0,  0,  0,  0,  0,  0,  2,  0,  1};
    // rows: 0 R3 in range, 1 R3 low, 2 R4 high, 3 R4 equality, 4 R5 third,
    //       5 R5 quarter, 6 R5 fifth, 7 R3 short window, 8 R6 stopped
    localparam int V_REQ  [NV] = '{ 3,  3,  4,  4,  5,  5,  5,  3,  6};

    logic        ref_clk = 1'b0;
    logic        ref_rst_n = 1'b0;
    logic        mon_clk = 1'b0;
    logic        mon_enable = 1'b0;
    logic [15:0] win_len = 16'd40;
    logic [15:0] thr_lo = 16'd0;
    logic [15:0] thr_hi = 16'hFFFF;
    logic        clr_we = 1'b0;
    logic [7:0]  clr_mask = 8'h00;
    logic [7:0]  status;
    logic        fault_low, fault_high, fault_loss;

    int n_chk = 0;
    int n_bad = 0;
    int mon_half = 0;

    clkmon_top uut (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .mon_clk   (mon_clk),
        .mon_enable(mon_enable),
        .win_len   (win_len),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .clr_we    (clr_we),
        .clr_mask  (clr_mask),
        .status    (status),
        .fault_low (fault_low),
        .fault_high(fault_high),
        .fault_loss(fault_loss)
    );

    always #(PERIOD/2) ref_clk = ~ref_clk;

    // monitored clock: edges always 3 ns off the 5 ns grid
    initial begin
        #3;
        forever begin
            if (mon_half == 0) begin
                mon_clk = 1'b0;
                #5;
            end else begin
                mon_clk = 1'b1;
                #(mon_half);
                mon_clk = 1'b0;
                #(mon_half);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic clear_bits(input logic [7:0] m);
        @(negedge ref_clk);
        clr_we   = 1'b1;
        clr_mask = m;
        @(negedge ref_clk);
        clr_we   = 1'b0;
        clr_mask = 8'h00;
        @(negedge ref_clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        cycles(4);
        chk("R1 status in reset", int'(status), 0);
        chk("R1 faults in reset", int'({fault_low, fault_high, fault_loss}), 0);
        ref_rst_n = 1'b1;
        cycles(3);
        chk("R1 status after reset", int'(status), 0);

        // R2 disabled with a stopped clock stays quiet
        cycles(200);
        chk("R2 idle while disabled", int'({status, fault_low, fault_high, fault_loss}), 0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            @(negedge ref_clk);
            mon_enable = 1'b0;
            cycles(3);
            win_len  = 16'(V_WIN[i]);
            thr_lo   = 16'(V_LO[i]);
            thr_hi   = 16'(V_HI[i]);
            mon_half = V_HALF[i];
            cycles(10);
            mon_enable = 1'b1;
            cycles(3 * V_WIN[i] + 20);
            clear_bits(8'hFF);
            cycles(2 * V_WIN[i] + 20);
            chk($sformatf("R%0d vec %0d status", V_REQ[i], i), int'(status), V_ST[i]);
            chk($sformatf("R%0d vec %0d fault_low", V_REQ[i], i), int'(fault_low), V_FL[i]);
            chk($sformatf("R%0d vec %0d fault_high", V_REQ[i], i), int'(fault_high), V_FH[i]);
            if (V_FX[i] != 2)
                chk($sformatf("R%0d vec %0d fault_loss", V_REQ[i], i), int'(fault_loss), V_FX[i]);
        end

        // R2 dropping enable clears everything on the next edge
        @(negedge ref_clk);
        mon_enable = 1'b0;
        @(negedge ref_clk);
        chk("R2 cleared after disable", int'({status, fault_low, fault_high, fault_loss}), 0);

        // R9 and R10: settle period hides a stopped clock, then loss shows
        win_len  = 16'd20;
        thr_lo   = 16'd1;
        thr_hi   = 16'd100;
        mon_half = 0;
        cycles(5);
        mon_enable = 1'b1;
        cycles(3);
        chk("R9 status during settle", int'(status), 0);
        chk("R9 no loss during settle", int'(fault_loss), 0);
        cycles(40);
        chk("R10 loss after settle", int'(fault_loss), 1);
        chk("R6 status stopped clock", int'(status), 9);

        // R7 sticky after the clock recovers
        mon_half = 10;
        cycles(100);
        chk("R7 sticky status", int'(status), 9);
        chk("R5 loss level released", int'(fault_loss), 0);
        chk("R3 low level released", int'(fault_low), 0);

        // R8 write one to clear, selective
        clear_bits(8'h02);
        chk("R8 clear of unset bit", int'(status), 9);
        clear_bits(8'h08);
        chk("R8 clear loss bit", int'(status), 1);
        clear_bits(8'h01);
        chk("R8 clear low bit", int'(status), 0);

        // R8 set wins over a clear while the clock is stopped
        mon_half = 0;
        cycles(30);
        clear_bits(8'h08);
        chk("R8 set wins over clear", int'(status[3]), 1);

        mon_enable = 1'b0;
        cycles(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule